// File: doc/BRIEF.md
# NAND Bus Timing Strobe Generator

This block turns single requests from a register-style front end into correctly timed control cycles on the asynchronous pins of an 8-bit raw NAND flash device. Each request names a cycle kind (command, address or plain data) and a direction. The block places the write data on the bus, drives the latch-enable lines, and produces one write-enable or read-enable pulse. Every pulse is framed by a programmed setup phase before it and a programmed hold phase after it. Read data is latched from the device bus as the read pulse ends.

A 32-bit timing word holds separate setup, pulse-width, hold and ready-wait values for reads and for writes. After each cycle the block stays busy for a programmable number of clocks before it resamples the device ready/busy line, so that line has time to fall. A configuration bit can hold chip enable asserted between cycles. A software-reset input returns the sequencer to idle and clears both the timing word and the configuration bit.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset the pins are idle: nand_ce_no, nand_we_no and nand_re_no are high; nand_cle_o, nand_ale_o, nand_dq_oe_o and ack_o are low; and rdy_o is low.
- R2: A write request (req_wr_i=1) holds nand_we_no high for wsetup+1 clocks after acceptance. It then drives nand_we_no low for wwidth+1 clocks, and keeps it high for whold+1 clocks before ack_o rises. wsetup sits at timing bits 19:16, whold at 23:20 and wwidth at 27:24. nand_re_no stays high throughout.
- R3: A read request (req_wr_i=0) follows the same pattern on nand_re_no. It uses rsetup at bits 3:0, rhold at 7:4 and rwidth at 11:8, and nand_we_no stays high throughout.
- R4: From setup to the end of hold, req_kind_i code 1 (command) drives nand_cle_o high and code 2 (address) drives nand_ale_o high. Codes 0 and 3 (data) drive neither. The two lines never rise together.
- R5: During a write cycle, nand_dq_oe_o is high and nand_dq_o holds the request's data unchanged from setup through hold.
- R6: rdata_o takes the value of nand_dq_i from the last clock in which nand_re_no is low.
- R7: After a write cycle the block stays busy for 2*n clocks, where n is the write ready-wait at bits 31:28. After a read it uses the read ready-wait at bits 15:12. A request presented during that time is stalled. With n=0 there is no wait.
- R8: rdy_o follows nand_rb_i through a two-stage synchronizer only while the block is idle. Between acceptance and the end of the ready-wait it holds its last value.
- R9: nand_ce_no is low during every cycle. Between cycles it is low when the force bit (written by cfg_wr_i with cfg_ce_force_i) is set, and high when that bit is clear.
- R10: soft_rst_i returns the block to idle on the next edge and clears the timing word and the force bit to zero. It wins over a cycle that would end on the same edge, and that cycle is not acknowledged.
- R11: ack_o is a one-clock pulse. A request still held high while ack_o is high is not taken as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software reset: idle and clear configuration |
| cfg_wr_i | input | 1 | Write strobe for the chip-enable force bit |
| cfg_ce_force_i | input | 1 | New value of the chip-enable force bit |
| tim_wr_i | input | 1 | Write strobe for the timing word |
| tim_data_i | input | 32 | New timing word (eight 4-bit fields) |
| req_i | input | 1 | Cycle request, held until ack_o |
| req_wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_kind_i | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_wdata_i | input | 8 | Byte to drive on a write cycle |
| ack_o | output | 1 | One-clock pulse when hold ends |
| rdata_o | output | 8 | Byte captured by the last read cycle |
| rdy_o | output | 1 | Sampled ready/busy level |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Device ready (1) / busy (0) |

## Verification
Software reset and the end of a cycle's hold phase can land on the same clock edge. In that case reset must win and the acknowledge must be dropped. The bench counts clocks from the request and raises soft_rst_i in exactly the last hold clock. It then checks three things: that no ack_o appears, that the pins go idle with chip enable released, and that the next cycle runs with one-clock phases, which proves the timing word was cleared. The acknowledge edge also meets a request that is still held. Back-to-back requests measure the exact clock at which the next strobe starts, with zero, small and maximum ready-waits.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_WAIT
  } phase_e;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_DAT2 = 2'd3
  } kind_e;

  // field slots within one direction; write slots are offset by FLD_PER_DIR
  localparam int unsigned FLD_SETUP   = 0;
  localparam int unsigned FLD_HOLD    = 1;
  localparam int unsigned FLD_WIDTH   = 2;
  localparam int unsigned FLD_WAIT    = 3;
  localparam int unsigned FLD_PER_DIR = 4;
  localparam int unsigned FLD_NUM     = 2 * FLD_PER_DIR;

endpackage

// File: rtl/nand_tim_regs.sv
module nand_tim_regs #(
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned TIM_W = nand_strobe_pkg::FLD_NUM * FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             tim_wr_i,
  input  logic [TIM_W-1:0] tim_data_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_ce_force_i,
  output logic [TIM_W-1:0] tim_o,
  output logic             ce_force_o
);

  logic [TIM_W-1:0] tim_q;
  logic             ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q <= '0;
      ce_q  <= 1'b0;
    end else if (soft_rst_i) begin
      tim_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      if (tim_wr_i) tim_q <= tim_data_i;
      if (cfg_wr_i) ce_q  <= cfg_ce_force_i;
    end
  end

  assign tim_o      = tim_q;
  assign ce_force_o = ce_q;

endmodule

// File: rtl/nand_field_sel.sv
module nand_field_sel #(
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned TIM_W = nand_strobe_pkg::FLD_NUM * FIELD_W
) (
  input  logic [TIM_W-1:0]   tim_i,
  input  logic               wr_i,
  output logic [FIELD_W-1:0] setup_o,
  output logic [FIELD_W-1:0] width_o,
  output logic [FIELD_W-1:0] hold_o,
  output logic [FIELD_W-1:0] wait_o
);
  import nand_strobe_pkg::*;

  logic [FIELD_W-1:0] fld [FLD_NUM];

  for (genvar g = 0; g < FLD_NUM; g++) begin : g_fld
    assign fld[g] = tim_i[g*FIELD_W +: FIELD_W];
  end

  // write fields occupy the upper half, so the direction is the slot msb
  assign setup_o = fld[{wr_i, 2'(FLD_SETUP)}];
  assign width_o = fld[{wr_i, 2'(FLD_WIDTH)}];
  assign hold_o  = fld[{wr_i, 2'(FLD_HOLD)}];
  assign wait_o  = fld[{wr_i, 2'(FLD_WAIT)}];

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  input  logic sample_en_i,
  output logic rdy_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rb_i};
      if (sample_en_i) rdy_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rdy_o = rdy_q;

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm #(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned CNT_W  = FIELD_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     soft_rst_i,
  input  logic                     req_i,
  input  logic                     req_wr_i,
  input  logic [1:0]               req_kind_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic [FIELD_W-1:0]       setup_i,
  input  logic [FIELD_W-1:0]       width_i,
  input  logic [FIELD_W-1:0]       hold_i,
  input  logic [FIELD_W-1:0]       wait_i,
  input  logic [DATA_W-1:0]        dq_i,
  output nand_strobe_pkg::phase_e  phase_o,
  output logic                     wr_o,
  output nand_strobe_pkg::kind_e   kind_o,
  output logic [DATA_W-1:0]        wdata_o,
  output logic                     ack_o,
  output logic [DATA_W-1:0]        rdata_o
);
  import nand_strobe_pkg::*;

  phase_e             phase_q;
  kind_e              kind_q;
  logic               wr_q;
  logic               ack_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FIELD_W-1:0] width_q, hold_q, wait_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= KIND_DATA;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
      width_q <= '0;
      hold_q  <= '0;
      wait_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (soft_rst_i) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          // ack gating keeps a still-held request from restarting
          if (req_i && !ack_q) begin
            phase_q <= PH_SETUP;
            cnt_q   <= CNT_W'(setup_i);
            width_q <= width_i;
            hold_q  <= hold_i;
            wait_q  <= wait_i;
            wr_q    <= req_wr_i;
            kind_q  <= kind_e'(req_kind_i);
            wdata_q <= req_wdata_i;
          end
        end
        PH_SETUP: begin
          if (cnt_done) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(width_q);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_done) begin
            phase_q <= PH_HOLD;
            cnt_q   <= CNT_W'(hold_q);
            if (!wr_q) rdata_q <= dq_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_done) begin
            ack_q <= 1'b1;
            if (wait_q == '0) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_WAIT;
              cnt_q   <= {wait_q, 1'b0} - CNT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt_done) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign wr_o    = wr_q;
  assign kind_o  = kind_q;
  assign wdata_o = wdata_q;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int unsigned FIELD_W     = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIM_W = nand_strobe_pkg::FLD_NUM * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_ce_force_i,
  input  logic              tim_wr_i,
  input  logic [TIM_W-1:0]  tim_data_i,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdy_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_rb_i
);
  import nand_strobe_pkg::*;

  logic [TIM_W-1:0]   tim;
  logic               ce_force;
  logic [FIELD_W-1:0] f_setup, f_width, f_hold, f_wait;
  phase_e             phase;
  kind_e              kind;
  logic               cyc_wr;
  logic [DATA_W-1:0]  cyc_wdata;
  logic               active, strobe;

  nand_tim_regs #(.FIELD_W(FIELD_W)) i_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .soft_rst_i     (soft_rst_i),
    .tim_wr_i       (tim_wr_i),
    .tim_data_i     (tim_data_i),
    .cfg_wr_i       (cfg_wr_i),
    .cfg_ce_force_i (cfg_ce_force_i),
    .tim_o          (tim),
    .ce_force_o     (ce_force)
  );

  nand_field_sel #(.FIELD_W(FIELD_W)) i_sel (
    .tim_i   (tim),
    .wr_i    (req_wr_i),
    .setup_o (f_setup),
    .width_o (f_width),
    .hold_o  (f_hold),
    .wait_o  (f_wait)
  );

  nand_phase_fsm #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .req_i       (req_i),
    .req_wr_i    (req_wr_i),
    .req_kind_i  (req_kind_i),
    .req_wdata_i (req_wdata_i),
    .setup_i     (f_setup),
    .width_i     (f_width),
    .hold_i      (f_hold),
    .wait_i      (f_wait),
    .dq_i        (nand_dq_i),
    .phase_o     (phase),
    .wr_o        (cyc_wr),
    .kind_o      (kind),
    .wdata_o     (cyc_wdata),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o)
  );

  nand_rb_sync #(.SYNC_STAGES(SYNC_STAGES)) i_rb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rb_i        (nand_rb_i),
    .sample_en_i (phase == PH_IDLE),
    .rdy_o       (rdy_o)
  );

  assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_STROBE);

  assign nand_ce_no   = !(ce_force || active);
  assign nand_cle_o   = active && (kind == KIND_CMD);
  assign nand_ale_o   = active && (kind == KIND_ADDR);
  assign nand_we_no   = !(strobe && cyc_wr);
  assign nand_re_no   = !(strobe && !cyc_wr);
  assign nand_dq_o    = cyc_wdata;
  assign nand_dq_oe_o = active && cyc_wr;

endmodule

// File: rtl/nand_strobe_gen_sva.sv
module nand_strobe_gen_sva #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              cfg_wr_i,
  input logic              cfg_ce_force_i,
  input logic              ack_o,
  input logic              nand_ce_no,
  input logic              nand_cle_o,
  input logic              nand_ale_o,
  input logic              nand_we_no,
  input logic              nand_re_no,
  input logic [DATA_W-1:0] nand_dq_o
);

  logic past_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_q <= 1'b0;
    else         past_q <= 1'b1;
  end

  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  assert_ack_after_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && $rose(ack_o)) |-> $past(nand_we_no && nand_re_no));

  assert_latch_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  assert_latch_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && (!nand_we_no || !nand_re_no)) |-> ($stable(nand_cle_o) && $stable(nand_ale_o)));

  assert_dq_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && !nand_we_no && $past(!nand_we_no)) |-> $stable(nand_dq_o));

  assert_strobe_ce_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);

  assert_ce_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_ce_force_i && !soft_rst_i) |=> !nand_ce_no);

  assert_soft_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (nand_we_no && nand_re_no && nand_ce_no && !nand_cle_o && !nand_ale_o && !ack_o));

  assert_ack_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

endmodule

bind nand_strobe_gen nand_strobe_gen_sva #(.DATA_W(DATA_W)) i_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .soft_rst_i     (soft_rst_i),
  .cfg_wr_i       (cfg_wr_i),
  .cfg_ce_force_i (cfg_ce_force_i),
  .ack_o          (ack_o),
  .nand_ce_no     (nand_ce_no),
  .nand_cle_o     (nand_cle_o),
  .nand_ale_o     (nand_ale_o),
  .nand_we_no     (nand_we_no),
  .nand_re_no     (nand_re_no),
  .nand_dq_o      (nand_dq_o)
);

// File: tb/test_nand_strobe_gen.sv
`timescale 1ns/1ps
module test_nand_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        cfg_ce_force_i = 1'b0;
  logic        tim_wr_i = 1'b0;
  logic [31:0] tim_data_i = '0;
  logic        req_i = 1'b0;
  logic        req_wr_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        ack_o;
  logic [7:0]  rdata_o;
  logic        rdy_o;
  logic        nand_ce_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no;
  logic [7:0]  nand_dq_o;
  logic        nand_dq_oe_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nand_strobe_gen i_nand_strobe_gen (
    .clk_i (clk), .rst_ni (rst_ni), .soft_rst_i (soft_rst_i),
    .cfg_wr_i (cfg_wr_i), .cfg_ce_force_i (cfg_ce_force_i),
    .tim_wr_i (tim_wr_i), .tim_data_i (tim_data_i),
    .req_i (req_i), .req_wr_i (req_wr_i), .req_kind_i (req_kind_i),
    .req_wdata_i (req_wdata_i), .ack_o (ack_o), .rdata_o (rdata_o),
    .rdy_o (rdy_o), .nand_ce_no (nand_ce_no), .nand_cle_o (nand_cle_o),
    .nand_ale_o (nand_ale_o), .nand_we_no (nand_we_no), .nand_re_no (nand_re_no),
    .nand_dq_o (nand_dq_o), .nand_dq_oe_o (nand_dq_oe_o),
    .nand_dq_i (nand_dq_i), .nand_rb_i (nand_rb_i)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_timing(input logic [31:0] word);
    @(negedge clk);
    tim_wr_i = 1'b1; tim_data_i = word;
    @(negedge clk);
    tim_wr_i = 1'b0;
  endtask

  task automatic set_ce(input bit v);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_ce_force_i = v;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  // Runs one cycle from request to the ack sample; req dropped at the ack sample.
  task automatic do_cycle(input logic [1:0] kind, input bit wr, input logic [7:0] data,
                          input int s, input int w, input int h);
    int n_pre = 0, n_str = 0, n_post = 0, guard = 0;
    int bad_ctl = 0, bad_ce = 0, bad_dq = 0, bad_other = 0;
    logic exp_cle, exp_ale, strobe, other;
    string rt;
    exp_cle = (kind == 2'd1);
    exp_ale = (kind == 2'd2);
    rt = wr ? "R2" : "R3";
    req_i = 1'b1; req_wr_i = wr; req_kind_i = kind; req_wdata_i = data;
    if (!wr) nand_dq_i = data;
    while (1) begin
      @(negedge clk);
      guard++;
      if (ack_o === 1'b1 || guard > 200) break;
      if (nand_cle_o !== exp_cle || nand_ale_o !== exp_ale) bad_ctl++;
      if (nand_ce_no !== 1'b0) bad_ce++;
      if (wr && (nand_dq_oe_o !== 1'b1 || nand_dq_o !== data)) bad_dq++;
      strobe = wr ? !nand_we_no : !nand_re_no;
      other  = wr ? !nand_re_no : !nand_we_no;
      if (other) bad_other++;
      if (strobe) begin
        if (!wr) nand_dq_i = data + 8'(n_str);
        n_str++;
      end else if (n_str == 0) n_pre++;
      else n_post++;
    end
    req_i = 1'b0;
    chk(ack_o === 1'b1, "R11", int'(ack_o), 1);
    chk(n_pre == s + 1, rt, n_pre, s + 1);
    chk(n_str == w + 1, rt, n_str, w + 1);
    chk(n_post == h + 1, rt, n_post, h + 1);
    chk(bad_other == 0, rt, bad_other, 0);
    chk(bad_ctl == 0, "R4", bad_ctl, 0);
    chk(bad_ce == 0, "R9", bad_ce, 0);
    if (wr) chk(bad_dq == 0, "R5", bad_dq, 0);
    else    chk(rdata_o === 8'(data + 8'(w)), "R6", int'(rdata_o), int'(8'(data + 8'(w))));
  endtask

  task automatic test_reset();
    chk(nand_ce_no === 1'b1 && nand_we_no === 1'b1 && nand_re_no === 1'b1, "R1",
        int'({nand_ce_no, nand_we_no, nand_re_no}), 7);
    chk(nand_cle_o === 1'b0 && nand_ale_o === 1'b0 && nand_dq_oe_o === 1'b0 && ack_o === 1'b0,
        "R1", int'({nand_cle_o, nand_ale_o, nand_dq_oe_o, ack_o}), 0);
    chk(rdy_o === 1'b0, "R1", int'(rdy_o), 0);
  endtask

  task automatic test_kinds();
    set_timing(32'h0421_0312);
    do_cycle(2'd1, 1'b1, 8'h70, 1, 4, 2); settle(10);
    do_cycle(2'd2, 1'b1, 8'h3c, 1, 4, 2); settle(10);
    do_cycle(2'd0, 1'b1, 8'ha5, 1, 4, 2); settle(10);
    do_cycle(2'd3, 1'b1, 8'h5a, 1, 4, 2); settle(10);
    do_cycle(2'd0, 1'b0, 8'h20, 2, 3, 1); settle(10);
  endtask

  task automatic test_bounds();
    set_timing(32'h0FFF_0000);
    do_cycle(2'd0, 1'b1, 8'hc3, 15, 15, 15); settle(10);
    do_cycle(2'd0, 1'b0, 8'h40, 0, 0, 0);    settle(10);
  endtask

  // First cycle, then a request raised one clock after its ack; measures the
  // sample index of the next strobe against the ready-wait n (R7).
  task automatic test_wait(input logic [31:0] word, input bit wr1, input int s1, input int w1,
                           input int h1, input int n, input bit wr2, input int s2);
    int j = 0, exp_j;
    exp_j = (n == 0) ? 3 + s2 : 2 * n + 2 + s2;
    set_timing(word);
    do_cycle(2'd0, wr1, 8'h11, s1, w1, h1);
    @(negedge clk); j = 1;
    chk(ack_o === 1'b0, "R11", int'(ack_o), 0);
    req_i = 1'b1; req_wr_i = wr2; req_kind_i = 2'd0; req_wdata_i = 8'h22;
    while (j < 100) begin
      @(negedge clk); j++;
      if ((wr2 ? nand_we_no : nand_re_no) === 1'b0) break;
    end
    chk(j == exp_j, "R7", j, exp_j);
    while (ack_o !== 1'b1 && j < 200) begin
      @(negedge clk); j++;
    end
    req_i = 1'b0;
    settle(40);
  endtask

  task automatic test_ready();
    set_timing(32'h000F_0000);
    nand_rb_i = 1'b0;
    settle(6);
    chk(rdy_o === 1'b0, "R8", int'(rdy_o), 0);
    @(negedge clk);
    nand_rb_i = 1'b1;
    req_i = 1'b1; req_wr_i = 1'b1; req_kind_i = 2'd0; req_wdata_i = 8'h01;
    settle(6);
    chk(rdy_o === 1'b0, "R8", int'(rdy_o), 0);
    while (ack_o !== 1'b1) @(negedge clk);
    req_i = 1'b0;
    settle(6);
    chk(rdy_o === 1'b1, "R8", int'(rdy_o), 1);
    nand_rb_i = 1'b0;
    settle(6);
    chk(rdy_o === 1'b0, "R8", int'(rdy_o), 0);
  endtask

  task automatic test_ce();
    set_ce(1'b1);
    settle(2);
    chk(nand_ce_no === 1'b0, "R9", int'(nand_ce_no), 0);
    set_timing(32'h0000_0000);
    do_cycle(2'd1, 1'b1, 8'h90, 0, 0, 0);
    settle(3);
    chk(nand_ce_no === 1'b0, "R9", int'(nand_ce_no), 0);
    set_ce(1'b0);
    settle(2);
    chk(nand_ce_no === 1'b1, "R9", int'(nand_ce_no), 1);
  endtask

  // Soft reset raised in the last hold clock: the edge that would ack resets instead.
  task automatic test_softrst_collide();
    int k;
    set_timing(32'h0121_0000);
    set_ce(1'b1);
    req_i = 1'b1; req_wr_i = 1'b1; req_kind_i = 2'd1; req_wdata_i = 8'hff;
    for (k = 1; k <= 7; k++) @(negedge clk);
    chk(nand_we_no === 1'b1 && nand_cle_o === 1'b1 && ack_o === 1'b0, "R10",
        int'({nand_we_no, nand_cle_o, ack_o}), 6);
    soft_rst_i = 1'b1;
    @(negedge clk);
    chk(ack_o === 1'b0, "R10", int'(ack_o), 0);
    chk(nand_cle_o === 1'b0 && nand_we_no === 1'b1 && nand_ce_no === 1'b1, "R10",
        int'({nand_cle_o, nand_we_no, nand_ce_no}), 3);
    soft_rst_i = 1'b0;
    req_i = 1'b0;
    @(negedge clk);
    chk(ack_o === 1'b0, "R10", int'(ack_o), 0);
    settle(3);
    do_cycle(2'd0, 1'b1, 8'h33, 0, 0, 0);
    settle(3);
    chk(nand_ce_no === 1'b1, "R10", int'(nand_ce_no), 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    settle(3);
    test_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    settle(3);
    test_reset();
    test_kinds();
    test_bounds();
    test_wait(32'h3100_1002, 1'b1, 0, 1, 0, 3, 1'b0, 2);
    test_wait(32'h3100_1002, 1'b0, 2, 0, 0, 1, 1'b1, 0);
    test_wait(32'h0421_0312, 1'b1, 1, 4, 2, 0, 1'b0, 2);
    test_wait(32'hF000_0000, 1'b1, 0, 0, 0, 15, 1'b0, 0);
    test_ready();
    test_ce();
    test_softrst_collide();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule